// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Status Flags

This block is a single-clock FIFO buffer with a write side (write enable, data in) and a read side (read enable, data out). It reports five active-low status outputs: an empty/output-ready pin, a full/input-ready pin, a half-full pin, and two programmable thresholds, almost-empty and almost-full. The thresholds come from two offset registers. Master reset loads them with parameter defaults, and a load strobe replaces them from input ports.

A timing mode is sampled from `modeSel` while master reset is held, and it stays fixed until the next master reset. In standard mode a read enable is needed to move a word to the output. In fall-through mode the oldest word appears on the output without a read request, and the first two status pins change meaning. Partial reset empties the buffer but keeps the mode and the offsets. Retransmit rewinds the read side to the first location so that the stored words can be read again.

Top module: `dualmode_fifo`

## Requirements
- R1: The level on `modeSel` at the clock edges where `mrstN` is low picks the mode (0 = standard, 1 = fall-through). That mode holds until the next master reset, whatever `modeSel` does in between.
- R2: Master reset is synchronous. It clears both pointers and `dataOut` (to 0) and loads the almost-empty offset with DEF_AE and the almost-full offset with DEF_AF.
- R3: In standard mode `emptyRdyN` is low when the buffer is empty and `fullRdyN` is low when it is full. In fall-through mode `emptyRdyN` is low while a valid word sits on `dataOut`, and `fullRdyN` is low while the memory can accept a write.
- R4: In standard mode `dataOut` takes the oldest word at the clock edge where `rdEnN` is low and the buffer is not empty. Otherwise `dataOut` holds its value.
- R5: In fall-through mode a word written into an empty buffer reaches `dataOut` at the edge after the write edge, and `emptyRdyN` falls at that same edge. With `rdEnN` low at an edge, the output moves to the next word, or `emptyRdyN` goes high if no word is left.
- R6: `halfN` is low while occupancy exceeds DEPTH/2. In fall-through mode, occupancy counts the word held on `dataOut`.
- R7: `almEmptyN` is low while occupancy is at most the almost-empty offset.
- R8: `almFullN` is low while occupancy is at least the capacity minus the almost-full offset. Capacity is DEPTH in standard mode and DEPTH+1 in fall-through mode.
- R9: A write while the memory holds DEPTH words is dropped. It changes neither the pointers nor the stored data.
- R10: A read while empty is dropped. `dataOut` and the pointers are unchanged.
- R11: With `prstN` low at an edge, both pointers clear and the output word becomes invalid. The mode and both offsets are kept, and the flags show an empty buffer at that edge.
- R12: With `rtN` low at an edge, the read pointer returns to location 0 and occupancy becomes the number of words written since reset (no wrap assumed). In fall-through mode word 0 reaches `dataOut` one edge later.
- R13: With `offLoad` high at an edge, the offsets take `aeOffIn` and `afOffIn`. The flags use the new values from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| mrstN | input | 1 | Master reset, active low, synchronous |
| prstN | input | 1 | Partial reset, active low, synchronous |
| modeSel | input | 1 | Mode sampled during master reset, 1 = fall-through |
| wrEnN | input | 1 | Write enable, active low |
| dataIn | input | WIDTH | Write data |
| rdEnN | input | 1 | Read enable, active low |
| rtN | input | 1 | Retransmit, active low |
| offLoad | input | 1 | Load both offset registers from the inputs |
| aeOffIn | input | AW+1 | New almost-empty offset |
| afOffIn | input | AW+1 | New almost-full offset |
| dataOut | output | WIDTH | Read data, registered |
| emptyRdyN | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| fullRdyN | output | 1 | Full (standard) or input-ready (fall-through), active low |
| halfN | output | 1 | Half-full, active low |
| almEmptyN | output | 1 | Almost-empty, active low |
| almFullN | output | 1 | Almost-full, active low |

## Verification
Every status pin and the standard-mode `dataOut` are registered from the next-state occupancy, so they settle at the same edge that performs the write, read, retransmit, reset or offset load. The bench drives inputs on the falling edge and samples on the following falling edge. The fall-through path adds one edge: a word written into an empty buffer is checked as not yet visible after its write edge and as present one edge later. A retransmit in fall-through mode gets the same two-step check.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifoMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWr;    // write dataIn into memory at wrAddr
    logic outLoad;  // move memory word at rdAddr onto dataOut
  } dpStrobe_t;

endpackage

// File: rtl/fifo_ctrl.sv
`timescale 1ns/1ps
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DEF_AE = 3,
  parameter int DEF_AF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int OW = AW + 1
) (
  input  logic          clk,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          modeSel,
  input  logic          wrEnN,
  input  logic          rdEnN,
  input  logic          rtN,
  input  logic          offLoad,
  input  logic [OW-1:0] aeOffIn,
  input  logic [OW-1:0] afOffIn,
  output dpStrobe_t     stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output fifoMode_e     curMode,
  output logic          emptyRdyN,
  output logic          fullRdyN,
  output logic          halfN,
  output logic          almEmptyN,
  output logic          almFullN
);

  localparam logic [OW-1:0] DEPTH_W = OW'(DEPTH);
  localparam logic [OW:0]   HALF_W  = (OW+1)'(DEPTH / 2);

  logic [OW-1:0] wrPtr, rdPtr, wrPtrNx, rdPtrNx;
  logic [OW-1:0] memCnt, cntNx;
  logic [OW-1:0] aeOff, afOff, aeOffNx, afOffNx;
  logic [OW:0]   occNx, capW;
  logic [OW+1:0] afSum;
  logic          outValid, outValidNx;
  logic          memEmpty, memFull, memFullNx;
  logic          isFwft, wrOk, rdReq, outLoad;

  assign isFwft   = (curMode == MODE_FWFT);
  assign memCnt   = wrPtr - rdPtr;
  assign memEmpty = (memCnt == '0);
  assign memFull  = (memCnt == DEPTH_W);

  // Request qualification
  assign wrOk  = mrstN && prstN && !wrEnN && !memFull;
  assign rdReq = mrstN && prstN && rtN && !rdEnN;

  always_comb begin
    if (isFwft)
      outLoad = mrstN && prstN && rtN && !memEmpty && (!outValid || !rdEnN);
    else
      outLoad = rdReq && !memEmpty;
  end

  always_comb begin
    if (!isFwft || !prstN || !rtN) outValidNx = 1'b0;
    else if (outLoad)              outValidNx = 1'b1;
    else if (rdReq)                outValidNx = 1'b0;
    else                           outValidNx = outValid;
  end

  assign wrPtrNx = !prstN ? '0 : wrPtr + OW'(wrOk);
  assign rdPtrNx = (!prstN || !rtN) ? '0 : rdPtr + OW'(outLoad);
  assign aeOffNx = offLoad ? aeOffIn : aeOff;
  assign afOffNx = offLoad ? afOffIn : afOff;

  // Next-state occupancy and capacity
  assign cntNx     = wrPtrNx - rdPtrNx;
  assign memFullNx = (cntNx == DEPTH_W);
  assign occNx     = {1'b0, cntNx} + (OW+1)'(isFwft & outValidNx);
  assign capW      = {1'b0, DEPTH_W} + (OW+1)'(isFwft);
  assign afSum     = {1'b0, occNx} + {2'b00, afOffNx};

  assign stb.memWr   = wrOk;
  assign stb.outLoad = outLoad;
  assign wrAddr      = wrPtr[AW-1:0];
  assign rdAddr      = rdPtr[AW-1:0];

  // Mode latch: sampled only during master reset
  always_ff @(posedge clk) begin
    if (!mrstN) curMode <= fifoMode_e'(modeSel);
  end

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      outValid  <= 1'b0;
      aeOff     <= OW'(DEF_AE);
      afOff     <= OW'(DEF_AF);
      emptyRdyN <= modeSel;
      fullRdyN  <= !modeSel;
      halfN     <= 1'b1;
      almEmptyN <= 1'b0;
      almFullN  <= 1'b1;
    end else begin
      wrPtr     <= wrPtrNx;
      rdPtr     <= rdPtrNx;
      outValid  <= outValidNx;
      aeOff     <= aeOffNx;
      afOff     <= afOffNx;
      emptyRdyN <= isFwft ? !outValidNx : (cntNx != '0);
      fullRdyN  <= isFwft ? memFullNx : !memFullNx;
      halfN     <= !(occNx > HALF_W);
      almEmptyN <= !(occNx <= {1'b0, aeOffNx});
      almFullN  <= !(afSum >= {1'b0, capW});
    end
  end

endmodule

// File: rtl/fifo_dpath.sv
`timescale 1ns/1ps
module fifo_dpath
  import fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             mrstN,
  input  dpStrobe_t        stb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.memWr) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!mrstN)           dataOut <= '0;
    else if (stb.outLoad) dataOut <= mem[rdAddr];
  end

endmodule

// File: rtl/dualmode_fifo.sv
`timescale 1ns/1ps
module dualmode_fifo
  import fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  parameter int DEF_AE = 3,
  parameter int DEF_AF = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int OW = AW + 1
) (
  input  logic             clk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             modeSel,
  input  logic             wrEnN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             rdEnN,
  input  logic             rtN,
  input  logic             offLoad,
  input  logic [OW-1:0]    aeOffIn,
  input  logic [OW-1:0]    afOffIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             emptyRdyN,
  output logic             fullRdyN,
  output logic             halfN,
  output logic             almEmptyN,
  output logic             almFullN
);

  dpStrobe_t     stb;
  logic [AW-1:0] wrAddr, rdAddr;
  fifoMode_e     curMode;

  fifo_ctrl #(.DEPTH(DEPTH), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_ctrl (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .modeSel(modeSel),
    .wrEnN(wrEnN), .rdEnN(rdEnN), .rtN(rtN), .offLoad(offLoad),
    .aeOffIn(aeOffIn), .afOffIn(afOffIn), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .curMode(curMode),
    .emptyRdyN(emptyRdyN), .fullRdyN(fullRdyN), .halfN(halfN),
    .almEmptyN(almEmptyN), .almFullN(almFullN)
  );

  fifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dpath (
    .clk(clk), .mrstN(mrstN), .stb(stb), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: rtl/fifo_chk.sv
`timescale 1ns/1ps
module fifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             mrstN,
  input logic             prstN,
  input logic             wrEnN,
  input logic             rdEnN,
  input logic             rtN,
  input logic             curMode,
  input logic [WIDTH-1:0] dataOut,
  input logic             emptyRdyN,
  input logic             fullRdyN,
  input logic             halfN,
  input logic             almEmptyN,
  input logic             almFullN
);

  // R1: mode stays put outside master reset
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!mrstN)
    mrstN |=> $stable(curMode));

  // R4: standard mode output holds without a read request
  p_dout_hold_r4: assert property (@(posedge clk) disable iff (!mrstN)
    (!curMode && rdEnN) |=> $stable(dataOut));

  // R7: standard-mode empty implies almost-empty
  p_empty_ae_r7: assert property (@(posedge clk) disable iff (!mrstN)
    (!curMode && !emptyRdyN) |-> !almEmptyN);

  // R8: full memory implies almost-full in both modes
  p_full_af_r8: assert property (@(posedge clk) disable iff (!mrstN)
    (curMode ? fullRdyN : !fullRdyN) |-> !almFullN);

  // R9: standard-mode full holds while nothing drains it
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!mrstN)
    (!curMode && !fullRdyN && rdEnN && rtN && prstN) |=> !fullRdyN);

  // R10: standard-mode empty holds while nothing fills it
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!mrstN)
    (!curMode && !emptyRdyN && wrEnN && rtN && prstN) |=> !emptyRdyN);

  // R11: partial reset empties the flags and keeps the mode
  p_prst_keep_r11: assert property (@(posedge clk) disable iff (!mrstN)
    !prstN |=> (halfN && almFullN && !almEmptyN && $stable(curMode)));

endmodule

bind dualmode_fifo fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .mrstN(mrstN), .prstN(prstN), .wrEnN(wrEnN),
  .rdEnN(rdEnN), .rtN(rtN), .curMode(curMode), .dataOut(dataOut),
  .emptyRdyN(emptyRdyN), .fullRdyN(fullRdyN), .halfN(halfN),
  .almEmptyN(almEmptyN), .almFullN(almFullN)
);

// File: tb/sim_dualmode_fifo.sv
`timescale 1ns/1ps
module sim_dualmode_fifo;

  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int OW    = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             mrstN = 1'b0, prstN = 1'b1, modeSel = 1'b0;
  logic             wrEnN = 1'b1, rdEnN = 1'b1, rtN = 1'b1, offLoad = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic [OW-1:0]    aeOffIn = '0, afOffIn = '0;
  logic [WIDTH-1:0] dataOut;
  logic             emptyRdyN, fullRdyN, halfN, almEmptyN, almFullN;

  int  nChk = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  dualmode_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DEF_AE(3), .DEF_AF(2)) u0 (
    .clk(clk), .mrstN(mrstN), .prstN(prstN), .modeSel(modeSel),
    .wrEnN(wrEnN), .dataIn(dataIn), .rdEnN(rdEnN), .rtN(rtN),
    .offLoad(offLoad), .aeOffIn(aeOffIn), .afOffIn(afOffIn),
    .dataOut(dataOut), .emptyRdyN(emptyRdyN), .fullRdyN(fullRdyN),
    .halfN(halfN), .almEmptyN(almEmptyN), .almFullN(almFullN)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic masterReset(input logic m);
    mrstN = 1'b0; modeSel = m;
    cyc(); cyc();
    mrstN = 1'b1; modeSel = ~m;   // changing modeSel later must not matter (R1)
  endtask

  task automatic wr(input logic [WIDTH-1:0] d);
    wrEnN = 1'b0; dataIn = d; cyc(); wrEnN = 1'b1;
  endtask

  task automatic rd();
    rdEnN = 1'b0; cyc(); rdEnN = 1'b1;
  endtask

  task automatic testResetStd();
    masterReset(1'b0);
    chk("R2 dataOut", dataOut, 0);
    chk("R3 std empty", emptyRdyN, 0);
    chk("R3 std not full", fullRdyN, 1);
    chk("R6 half", halfN, 1);
    chk("R7 ae", almEmptyN, 0);
    chk("R8 af", almFullN, 1);
  endtask

  task automatic testBasicStd();
    for (int i = 0; i < 3; i++) wr(8'hA0 + 8'(i));
    chk("R7 occ3 ae", almEmptyN, 0);
    chk("R4 no fall-through", dataOut, 0);
    chk("R3 not empty", emptyRdyN, 1);
    wr(8'hA3);
    chk("R7 occ4 ae", almEmptyN, 1);
    for (int i = 0; i < 4; i++) begin
      rd();
      chk("R4 read data", dataOut, 8'hA0 + 8'(i));
    end
    chk("R3 empty again", emptyRdyN, 0);
    rd();
    chk("R10 dataOut held", dataOut, 8'hA3);
    chk("R10 still empty", emptyRdyN, 0);
    wr(8'h77); rd();
    chk("R10 pointers intact", dataOut, 8'h77);
  endtask

  task automatic testFillStd();
    masterReset(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      wr(8'h10 + 8'(i));
      if (i == 7)  chk("R6 occ8 half", halfN, 1);
      if (i == 8)  chk("R6 occ9 half", halfN, 0);
      if (i == 12) chk("R8 occ13 af", almFullN, 1);
      if (i == 13) chk("R8 occ14 af", almFullN, 0);
      if (i == 14) chk("R3 occ15 full", fullRdyN, 1);
    end
    chk("R3 full", fullRdyN, 0);
    wr(8'hEE);
    chk("R9 still full", fullRdyN, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R9 data intact", dataOut, 8'h10 + 8'(i));
      if (i == 0) chk("R3 not full after read", fullRdyN, 1);
    end
    chk("R9 empty after drain", emptyRdyN, 0);
  endtask

  task automatic testRetransmitStd();
    masterReset(1'b0);
    for (int i = 0; i < 5; i++) wr(8'h30 + 8'(i));
    rd(); rd(); rd();
    chk("R4 third word", dataOut, 8'h32);
    chk("R7 occ2 ae", almEmptyN, 0);
    rtN = 1'b0; cyc(); rtN = 1'b1;
    chk("R12 occupancy restored", almEmptyN, 1);
    chk("R12 dataOut unchanged", dataOut, 8'h32);
    rd();
    chk("R12 reread word0", dataOut, 8'h30);
  endtask

  task automatic testOffsetsPrst();
    masterReset(1'b0);
    aeOffIn = 6; afOffIn = 5; offLoad = 1'b1; cyc(); offLoad = 1'b0;
    prstN = 1'b0; cyc(); prstN = 1'b1;
    for (int i = 0; i < 11; i++) begin
      wr(8'h60 + 8'(i));
      if (i == 5)  chk("R13 R11 occ6 ae", almEmptyN, 0);
      if (i == 6)  chk("R13 R11 occ7 ae", almEmptyN, 1);
      if (i == 9)  chk("R13 occ10 af", almFullN, 1);
      if (i == 10) chk("R13 occ11 af", almFullN, 0);
    end
    prstN = 1'b0; cyc(); prstN = 1'b1;
    chk("R11 empty", emptyRdyN, 0);
    chk("R11 af clear", almFullN, 1);
    chk("R11 ae set", almEmptyN, 0);
    masterReset(1'b0);
    for (int i = 0; i < 4; i++) wr(8'h01);
    chk("R13 default ae restored", almEmptyN, 1);
  endtask

  task automatic testFwftBasic();
    masterReset(1'b1);
    chk("R3 fwft not ready", emptyRdyN, 1);
    chk("R3 fwft input ready", fullRdyN, 0);
    chk("R1 fwft dataOut", dataOut, 0);
    wr(8'hB0);
    chk("R5 not yet visible", emptyRdyN, 1);
    cyc();
    chk("R5 fall-through ready", emptyRdyN, 0);
    chk("R5 fall-through data", dataOut, 8'hB0);
    wr(8'hB1); wr(8'hB2);
    rd();
    chk("R5 advance B1", dataOut, 8'hB1);
    rd();
    chk("R5 advance B2", dataOut, 8'hB2);
    rd();
    chk("R5 drained", emptyRdyN, 1);
    chk("R5 data held", dataOut, 8'hB2);
    rtN = 1'b0; cyc(); rtN = 1'b1;
    chk("R12 fwft invalid", emptyRdyN, 1);
    cyc();
    chk("R12 fwft ready", emptyRdyN, 0);
    chk("R12 fwft word0", dataOut, 8'hB0);
  endtask

  task automatic testFwftFill();
    masterReset(1'b1);
    for (int i = 0; i < DEPTH + 1; i++) begin
      wr(8'h40 + 8'(i));
      if (i == 8)  chk("R6 fwft occ9 half", halfN, 0);
      if (i == 13) chk("R8 fwft occ14 af", almFullN, 1);
      if (i == 14) chk("R8 fwft occ15 af", almFullN, 0);
      if (i == 15) chk("R3 fwft occ16 ready", fullRdyN, 0);
    end
    chk("R3 fwft occ17 full", fullRdyN, 1);
    wr(8'hEE);
    chk("R9 fwft still full", fullRdyN, 1);
    chk("R5 head word", dataOut, 8'h40);
    prstN = 1'b0; cyc(); prstN = 1'b1;
    chk("R11 fwft not ready", emptyRdyN, 1);
    chk("R11 fwft input ready", fullRdyN, 0);
    wr(8'h55);
    cyc();
    chk("R11 mode kept", emptyRdyN, 0);
    chk("R11 mode kept data", dataOut, 8'h55);
  endtask

  initial begin
    @(negedge clk);
    testResetStd();
    testBasicStd();
    testFillStd();
    testRetransmitStd();
    testOffsetsPrst();
    testFwftBasic();
    testFwftFill();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule